// File: doc/BRIEF.md
# Multi-Sensor Thermal Monitor Controller

This controller supervises up to eight on-die temperature sensors through a simple 32-bit register bus. A programmable detection period drives a free-running schedule. On each expiry every enabled sensor's ADC word is latched. Each latched word is compared against two per-sensor levels: a lower warning level and a higher trip level. Each hit sets a sticky raw status bit, and software clears these bits by writing ones.

Interrupt enables select which raw bits reach the masked status and the interrupt pin. A separate hardware path asserts an overheat line toward an external power manager, so a trip can shut the system down without any software handler.

Software first requests a configuration window and polls a busy flag until it reads low. It then configures the block and enables it. A pending flag stays high until the first conversion after enable has landed.

The register bus is single-cycle: a write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. The bus never stalls, so there is no back-pressure on either side. The sensor inputs are plain levels that are sampled only on a detection tick.

Top module: `thm_monitor`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `ovh_o` are low.
- R2: On each detection tick, each sensor whose enable (control bit n+2) is set captures its input. The captured value reads at offset 0x5C+4n in bits 9:0, and bits 31:10 read zero. A disabled sensor keeps its previous value.
- R3: Each sensor has a threshold register at offset 0x2C+4n, with the warning level in bits 9:0 and the trip level in bits 19:10. A captured value that is greater than or equal to the warning level sets raw status bit n (offset 0x0C). A value greater than or equal to the trip level sets raw bit n+8.
- R4: Writing to offset 0x14 clears each raw status bit 24:0 written as one, and the register reads zero. Offset 0x18 returns the pattern of the last such write. A raw bit falls only through such a write.
- R5: Masked status (offset 0x08) equals raw status gated as follows: bit n by enable bit n, bit n+8 by enable bit n+8, and the whole register by enable bit 26, where the enable register is at offset 0x04. `irq_o` is the OR of the masked status. Only enable bits 26, 25, 15:8 and 7:0 are stored.
- R6: `ovh_o` is high while enable bit 25 is set and some sensor n has both enable bit n and raw bit n+8 set. `ovh_o` stays high until that raw bit is cleared.
- R7: Writing a one to control bit 12 makes control bits 12 and 13 read one for exactly 4 cycles, after which both read zero.
- R8: Offset 0x54 bit 0 rises when the global enable (control bit 0) goes from zero to one. It falls at the first tick that captures at least one sensor, or when the global enable is cleared.
- R9: Detection ticks occur only while control bits 0 (global enable) and 1 (monitor enable) are both set. Clearing the global enable freezes the samples and keeps all configuration registers.
- R10: A tick occurs every P+1 cycles, where P is the 20-bit detection period at offset 0x10. Offset 0x4C stores a 16-bit monitor period and offset 0x50 a 4-bit monitor mode. Unstored bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sens_data_i | input | NS*SMP_W | Packed sensor ADC words, sensor n at bits n*10 upward |
| irq_o | output | 1 | Interrupt, the OR of masked status |
| ovh_o | output | 1 | Overheat request to the power manager |

## Verification
A period counter that drifts would show up as a sample register changing too early or too late after enable. With a long period, this is visible within one period. A raw status bit lost or set on the wrong side of the comparison would show on the next read of offset 0x0C, one tick after the input is applied. A stuck set-ready counter would keep bit 13 high past its fourth cycle. A wrong overheat latch would either leave `ovh_o` high after the trip bit is cleared or drop it after only the warning bit is cleared.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_IEN   = 8'h04;
  localparam logic [7:0] A_MSTS  = 8'h08;
  localparam logic [7:0] A_RSTS  = 8'h0C;
  localparam logic [7:0] A_DPER  = 8'h10;
  localparam logic [7:0] A_CLR   = 8'h14;
  localparam logic [7:0] A_CLRST = 8'h18;
  localparam logic [7:0] A_THR0  = 8'h2C;
  localparam logic [7:0] A_MPER  = 8'h4C;
  localparam logic [7:0] A_MMODE = 8'h50;
  localparam logic [7:0] A_PEND  = 8'h54;
  localparam logic [7:0] A_SMP0  = 8'h5C;

  localparam int B_GEN     = 0;
  localparam int B_MEN     = 1;
  localparam int B_SEN0    = 2;
  localparam int B_RDYREQ  = 12;
  localparam int B_RDYBUSY = 13;
  localparam int B_GOVH    = 25;
  localparam int B_IRQEN   = 26;

  localparam int STS_W     = 25;
  localparam int TRIP_BASE = 8;
endpackage

// File: rtl/thm_period_timer.sv
module thm_period_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // A tick restarts the count, so two ticks in a row need a zero period.
  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && period_i != '0) |=> (!tick_o || period_i == '0));
endmodule

// File: rtl/thm_sensor_slice.sv
module thm_sensor_slice #(
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [SMP_W-1:0] din_i,
  input  logic [SMP_W-1:0] hot_lvl_i,
  input  logic [SMP_W-1:0] trip_lvl_i,
  output logic [SMP_W-1:0] sample_o,
  output logic             hot_hit_o,
  output logic             trip_hit_o
);
  logic capture;

  assign capture    = tick_i & en_i;
  assign hot_hit_o  = capture && (din_i >= hot_lvl_i);
  assign trip_hit_o = capture && (din_i >= trip_lvl_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sample_o <= '0;
    else if (capture) sample_o <= din_i;
  end

  p_sample_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(sample_o));
endmodule

// File: rtl/thm_status.sv
module thm_status import thm_pkg::*; #(
  parameter int NS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    hot_hit_i,
  input  logic [NS-1:0]    trip_hit_i,
  input  logic             clr_we_i,
  input  logic [STS_W-1:0] clr_mask_i,
  input  logic [31:0]      ien_i,
  output logic [STS_W-1:0] raw_o,
  output logic [STS_W-1:0] masked_o,
  output logic             irq_o,
  output logic             ovh_o
);
  logic [STS_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[0 +: NS]         = hot_hit_i;
    set_vec[TRIP_BASE +: NS] = trip_hit_i;
  end

  assign clr_vec = clr_we_i ? clr_mask_i : '0;

  // A new hit in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= (raw_o & ~clr_vec) | set_vec;
  end

  assign masked_o = ien_i[B_IRQEN] ? (raw_o & ien_i[STS_W-1:0]) : '0;
  assign irq_o    = |masked_o;
  assign ovh_o    = ien_i[B_GOVH] & (|(ien_i[NS-1:0] & raw_o[TRIP_BASE +: NS]));

  p_clear_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_o) & ~raw_o) & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/thm_monitor.sv
module thm_monitor import thm_pkg::*; #(
  parameter int NS         = 8,
  parameter int SMP_W      = 10,
  parameter int DET_W      = 20,
  parameter int MON_W      = 16,
  parameter int MODE_W     = 4,
  parameter int RDY_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NS*SMP_W-1:0] sens_data_i,
  output logic                irq_o,
  output logic                ovh_o
);
  localparam int THR_W = 2 * SMP_W;
  localparam int RC_W  = $clog2(RDY_CYCLES + 1);
  localparam logic [31:0] SEN_ONES = 32'((1 << NS) - 1);
  localparam logic [31:0] IEN_MASK = (32'(1) << B_IRQEN) | (32'(1) << B_GOVH) |
                                     (SEN_ONES << TRIP_BASE) | SEN_ONES;

  logic              gen_q, men_q, pend_q, tick, busy;
  logic [NS-1:0]     sen_q;
  logic [RC_W-1:0]   rdy_cnt;
  logic [31:0]       ien_q;
  logic [DET_W-1:0]  dper_q;
  logic [MON_W-1:0]  mper_q;
  logic [MODE_W-1:0] mmode_q;
  logic [THR_W-1:0]  thr_q [NS];
  logic [SMP_W-1:0]  smp   [NS];
  logic [STS_W-1:0]  clrst_q, raw, masked;
  logic [NS-1:0]     hot_hit, trip_hit;
  logic              wr_ctl, wr_clr, pend_set;

  assign wr_ctl   = bus_we && (bus_addr == A_CTRL);
  assign wr_clr   = bus_we && (bus_addr == A_CLR);
  assign busy     = (rdy_cnt != '0);
  assign pend_set = wr_ctl && bus_wdata[B_GEN] && !gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      men_q   <= 1'b0;
      sen_q   <= '0;
      ien_q   <= '0;
      dper_q  <= '0;
      mper_q  <= '0;
      mmode_q <= '0;
      clrst_q <= '0;
      for (int n = 0; n < NS; n++) thr_q[n] <= '0;
    end else if (bus_we) begin
      if (wr_ctl) begin
        gen_q <= bus_wdata[B_GEN];
        men_q <= bus_wdata[B_MEN];
        sen_q <= bus_wdata[B_SEN0 +: NS];
      end
      if (bus_addr == A_IEN)   ien_q   <= bus_wdata & IEN_MASK;
      if (bus_addr == A_DPER)  dper_q  <= bus_wdata[DET_W-1:0];
      if (bus_addr == A_MPER)  mper_q  <= bus_wdata[MON_W-1:0];
      if (bus_addr == A_MMODE) mmode_q <= bus_wdata[MODE_W-1:0];
      if (wr_clr)              clrst_q <= bus_wdata[STS_W-1:0];
      for (int n = 0; n < NS; n++)
        if (bus_addr == 8'(A_THR0 + 4 * n)) thr_q[n] <= bus_wdata[THR_W-1:0];
    end
  end

  // Set-ready window: a fixed countdown, request and busy share it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   rdy_cnt <= '0;
    else if (wr_ctl && bus_wdata[B_RDYREQ] && !busy) rdy_cnt <= RC_W'(RDY_CYCLES);
    else if (busy)                                rdy_cnt <= rdy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (pend_set)            pend_q <= 1'b1;
    else if (!gen_q)              pend_q <= 1'b0;
    else if (tick && (|sen_q))    pend_q <= 1'b0;
  end

  thm_period_timer #(.CNT_W(DET_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (gen_q & men_q),
    .period_i (dper_q),
    .tick_o   (tick)
  );

  for (genvar n = 0; n < NS; n++) begin : g_sens
    thm_sensor_slice #(.SMP_W(SMP_W)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .en_i       (sen_q[n]),
      .din_i      (sens_data_i[n*SMP_W +: SMP_W]),
      .hot_lvl_i  (thr_q[n][SMP_W-1:0]),
      .trip_lvl_i (thr_q[n][THR_W-1:SMP_W]),
      .sample_o   (smp[n]),
      .hot_hit_o  (hot_hit[n]),
      .trip_hit_o (trip_hit[n])
    );
  end

  thm_status #(.NS(NS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .hot_hit_i  (hot_hit),
    .trip_hit_i (trip_hit),
    .clr_we_i   (wr_clr),
    .clr_mask_i (bus_wdata[STS_W-1:0]),
    .ien_i      (ien_q),
    .raw_o      (raw),
    .masked_o   (masked),
    .irq_o      (irq_o),
    .ovh_o      (ovh_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_GEN]        = gen_q;
        bus_rdata[B_MEN]        = men_q;
        bus_rdata[B_SEN0 +: NS] = sen_q;
        bus_rdata[B_RDYREQ]     = busy;
        bus_rdata[B_RDYBUSY]    = busy;
      end
      A_IEN:   bus_rdata              = ien_q;
      A_MSTS:  bus_rdata[STS_W-1:0]   = masked;
      A_RSTS:  bus_rdata[STS_W-1:0]   = raw;
      A_DPER:  bus_rdata[DET_W-1:0]   = dper_q;
      A_CLRST: bus_rdata[STS_W-1:0]   = clrst_q;
      A_MPER:  bus_rdata[MON_W-1:0]   = mper_q;
      A_MMODE: bus_rdata[MODE_W-1:0]  = mmode_q;
      A_PEND:  bus_rdata[0]           = pend_q;
      default: ;
    endcase
    for (int n = 0; n < NS; n++) begin
      if (bus_addr == 8'(A_THR0 + 4 * n)) bus_rdata[THR_W-1:0] = thr_q[n];
      if (bus_addr == 8'(A_SMP0 + 4 * n)) bus_rdata[SMP_W-1:0] = smp[n];
    end
  end

  p_busy_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[B_RDYREQ] && !busy) |=> busy);

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (|sen_q) && !pend_set) |=> !pend_q);
endmodule

// File: tb/test_thm_monitor.sv
module test_thm_monitor;
  localparam int NS = 8;
  localparam int SW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS*SW-1:0] sens = '0;
  logic          irq_o, ovh_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thm_monitor i_thm_monitor (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sens_data_i(sens),
    .irq_o(irq_o), .ovh_o(ovh_o)
  );

  // {sensor[34:32], din[31:22], warn[21:12], trip[11:2], exp_warn[1], exp_trip[0]}
  localparam logic [34:0] VEC [6] = '{
    {3'd0, 10'd100,  10'd200,  10'd300,  1'b0, 1'b0},
    {3'd1, 10'd200,  10'd200,  10'd300,  1'b1, 1'b0},
    {3'd2, 10'd299,  10'd200,  10'd300,  1'b1, 1'b0},
    {3'd3, 10'd300,  10'd200,  10'd300,  1'b1, 1'b1},
    {3'd7, 10'd1023, 10'd1023, 10'd1023, 1'b1, 1'b1},
    {3'd5, 10'd0,    10'd0,    10'd1,    1'b1, 1'b0}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int s;
    logic [9:0] din, wl, tl;
    logic [31:0] exp;

    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd(8'h00, d); chk("R1", "control", d, 32'h0);
    rd(8'h04, d); chk("R1", "int enable", d, 32'h0);
    rd(8'h0C, d); chk("R1", "raw status", d, 32'h0);
    rd(8'h5C, d); chk("R1", "sample0", d, 32'h0);
    chk("R1", "irq_o", 32'(irq_o), 32'h0);
    chk("R1", "ovh_o", 32'(ovh_o), 32'h0);

    // R7 set-ready window of four cycles
    wr(8'h00, 32'h1000);
    rd(8'h00, d); chk("R7", "busy just after request", d[13:12], 32'h3);
    wait_cyc(3);
    rd(8'h00, d); chk("R7", "busy at fourth cycle", d[13:12], 32'h3);
    wait_cyc(1);
    rd(8'h00, d); chk("R7", "busy after window", d[13:12], 32'h0);

    // R10 field widths
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, d); chk("R10", "monitor period width", d, 32'hFFFF);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, d); chk("R10", "monitor mode width", d, 32'hF);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R10", "detect period width", d, 32'hF_FFFF);

    // R10 / R8 / R2 long period, sensor0 enabled, sensor1 not
    wr(8'h10, 32'd100);
    sens[0*SW +: SW] = 10'd55;
    sens[1*SW +: SW] = 10'd9;
    wr(8'h00, 32'h7);
    rd(8'h54, d); chk("R8", "pending after enable", d, 32'h1);
    wait_cyc(50);
    rd(8'h5C, d); chk("R10", "no sample before period", d, 32'h0);
    wait_cyc(60);
    rd(8'h5C, d); chk("R2", "sample0 captured", d, 32'd55);
    rd(8'h60, d); chk("R2", "disabled sensor1 untouched", d, 32'h0);
    rd(8'h54, d); chk("R8", "pending after first sample", d, 32'h0);

    // R9 global disable freezes sampling, keeps configuration
    wr(8'h00, 32'h6);
    sens[0*SW +: SW] = 10'd77;
    wait_cyc(220);
    rd(8'h5C, d); chk("R9", "sample frozen", d, 32'd55);
    rd(8'h10, d); chk("R9", "period kept", d, 32'd100);
    rd(8'h00, d); chk("R9", "sensor enables kept", d, 32'h6);

    // R3 / R2 vector table
    wr(8'h10, 32'd3);
    for (int i = 0; i < 6; i++) begin
      s   = int'(VEC[i][34:32]);
      din = VEC[i][31:22];
      wl  = VEC[i][21:12];
      tl  = VEC[i][11:2];
      exp = (32'(VEC[i][1]) << s) | (32'(VEC[i][0]) << (s + 8));
      wr(8'h00, 32'h0);
      wr(8'(8'h2C + 4 * s), {12'h0, tl, wl});
      sens[s*SW +: SW] = din;
      wr(8'h14, 32'h01FF_FFFF);
      wr(8'h00, 32'h3 | (32'h4 << s));
      wait_cyc(12);
      rd(8'h0C, d); chk("R3", $sformatf("raw status vector %0d", i), d, exp);
      rd(8'(8'h5C + 4 * s), d); chk("R2", $sformatf("sample vector %0d", i), d, 32'(din));
    end

    // R5 / R6 interrupt and overheat path on sensor2
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h01FF_FFFF);
    wr(8'h34, (32'd300 << 10) | 32'd200);
    sens[2*SW +: SW] = 10'd350;
    wr(8'h04, 32'h0600_0404);
    wr(8'h00, 32'h13);
    wait_cyc(12);
    chk("R6", "overheat asserted", 32'(ovh_o), 32'h1);
    chk("R5", "irq asserted", 32'(irq_o), 32'h1);
    rd(8'h08, d); chk("R5", "masked status", d, 32'h404);
    wr(8'h04, 32'h0200_0404);
    rd(8'h08, d); chk("R5", "masked with irq disabled", d, 32'h0);
    chk("R5", "irq off", 32'(irq_o), 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h4);
    rd(8'h0C, d); chk("R4", "warning bit cleared only", d, 32'h400);
    chk("R6", "overheat held by trip bit", 32'(ovh_o), 32'h1);
    rd(8'h18, d); chk("R4", "clear pattern readback", d, 32'h4);
    wr(8'h14, 32'h400);
    rd(8'h0C, d); chk("R4", "trip bit cleared", d, 32'h0);
    chk("R6", "overheat dropped", 32'(ovh_o), 32'h0);
    rd(8'h14, d); chk("R4", "clear register reads zero", d, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R5", "enable bits stored", d, 32'h0600_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule